// File: doc/BRIEF.md
# Quadratic Bezier Pixel Interpolator

This block turns one quadratic Bezier segment into a stream of 8-bit pixel coordinates for a pair of beam-steering DACs. It latches three control points, which are signed fixed-point values with 10 integer and 18 fraction bits. It then walks the curve parameter t from 0 to 1 in steps of 1/512. For each t it forms the weighted sum (1-t)^2·P0 + 2t(1-t)·P1 + t^2·P2 on both axes and takes the floor to an integer pixel. The pixel is clamped to the 0..255 range.

A pixel is offered on the output only when it differs from the previous accepted pixel. The first pixel of a segment is always offered. Because of this, consecutive outputs never repeat and the beam does not dwell on any one spot. Output uses a valid/ready handshake. A one-cycle done pulse ends the segment, after which the block accepts the next segment. A path sequencer drives the start strobe and consumes the points, and a FIFO toward the slow DAC clock sits behind it.

Top module: `qbez_pixel_stepper`

## Requirements
- R1: While rst_ni is low and after its release, out_val_o and done_o are 0 until a segment is started.
- R2: A segment evaluates every t = k/512 for k = 0,1,...,512 in increasing order. The first accepted pixel is the pixel at k=0 and the last accepted pixel is the pixel at k=512.
- R3: For a given k, the pixel on each axis is floor(((512-k)^2·P0 + 2k(512-k)·P1 + k^2·P2) / 2^36), where each P is the raw signed 28-bit coordinate with 18 fraction bits.
- R4: A pixel below 0 is output as 0, and a pixel of 256 or more is output as 255. Other values are output unchanged.
- R5: The pixel at k=0 is always offered, even if it equals the last pixel of the previous segment.
- R6: After the first pixel, a pixel is offered only if its x or its y differs from the last accepted pixel. A segment whose control points all map to one pixel yields exactly one point.
- R7: While out_val_o is 1 and out_rdy_i is 0, out_val_o stays 1 and out_x_o and out_y_o hold their values. The last-accepted pixel changes only on a completed handshake.
- R8: Each k is decided 3 cycles after the clock edge that started it: either the edge where in_val_i was accepted (k=0) or the edge that completed the previous handshake or skipped the previous k. out_val_o rises on that decision edge when the pixel is offered.
- R9: After k=512 is handled (skipped, or its handshake completed), done_o is 1 for exactly one cycle and out_val_o is 0 in that cycle.
- R10: in_val_i is ignored while a segment is in progress. It is sampled only when the block is idle, which includes the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_val_i | input | 1 | Start strobe; the control points are latched when idle |
| p0_x_i | input | 28 | Start point x, signed 10.18 |
| p0_y_i | input | 28 | Start point y, signed 10.18 |
| p1_x_i | input | 28 | Control point x, signed 10.18 |
| p1_y_i | input | 28 | Control point y, signed 10.18 |
| p2_x_i | input | 28 | End point x, signed 10.18 |
| p2_y_i | input | 28 | End point y, signed 10.18 |
| out_rdy_i | input | 1 | Consumer accepts the offered pixel |
| out_val_o | output | 1 | A pixel is offered |
| out_x_o | output | 8 | Offered pixel x |
| out_y_o | output | 8 | Offered pixel y |
| done_o | output | 1 | One-cycle end-of-segment pulse |

## Verification
Every parameter step costs a fixed three cycles from the edge that starts it to the edge that decides it: two register stages for the weight and product pipeline, plus the decision itself. A handshake adds exactly the stall cycles the consumer imposes. The bench advances a behavioural timeline on each rising edge using these counts. At every falling edge it compares out_val_o, done_o and the offered pixel against that timeline. The expected pixels come from exact 64-bit integer arithmetic, so a result that is one cycle early or late, or one pixel off, is reported in the cycle where it occurs.

// File: rtl/qbez_pkg.sv
package qbez_pkg;
  localparam int PIPE_LAT = 2;  // weight stage + product stage

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DECIDE,
    ST_EMIT
  } qbez_st_e;
endpackage

// File: rtl/qbez_weight_gen.sv
module qbez_weight_gen #(
  parameter int TBITS = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TBITS:0]       k_i,
  output logic [2*TBITS:0]     w0_o,
  output logic [2*TBITS:0]     w1_o,
  output logic [2*TBITS:0]     w2_o
);
  localparam int KW = TBITS + 1;
  localparam int WW = 2 * TBITS + 1;
  localparam logic [KW-1:0] N = KW'(1 << TBITS);

  logic [KW-1:0] km;
  logic [WW-1:0] ka, kb;

  assign km = N - k_i;
  assign ka = WW'(k_i);
  assign kb = WW'(km);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_o <= '0;
      w1_o <= '0;
      w2_o <= '0;
    end else begin
      w0_o <= kb * kb;
      w1_o <= (ka * kb) << 1;  // doubling by shift
      w2_o <= ka * ka;
    end
  end
endmodule

// File: rtl/qbez_axis_mac.sv
module qbez_axis_mac #(
  parameter int PW    = 28,
  parameter int FRAC  = 18,
  parameter int TBITS = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PW-1:0]     p0_i,
  input  logic signed [PW-1:0]     p1_i,
  input  logic signed [PW-1:0]     p2_i,
  input  logic [2*TBITS:0]         w0_i,
  input  logic [2*TBITS:0]         w1_i,
  input  logic [2*TBITS:0]         w2_i,
  output logic signed [PW-FRAC-1:0] int_o
);
  localparam int WW = 2 * TBITS + 1;
  localparam int AW = PW + WW + 3;
  localparam int IW = PW - FRAC;
  localparam int SH = 2 * TBITS + FRAC;

  logic signed [AW-1:0] e0, e1, e2, f0, f1, f2, acc;

  always_comb begin
    e0  = AW'(p0_i);
    e1  = AW'(p1_i);
    e2  = AW'(p2_i);
    f0  = AW'(w0_i);
    f1  = AW'(w1_i);
    f2  = AW'(w2_i);
    acc = e0 * f0 + e1 * f1 + e2 * f2;
  end

  // keep only the floored integer part
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_o <= '0;
    else         int_o <= IW'(acc >>> SH);
  end
endmodule

// File: rtl/qbez_sat.sv
module qbez_sat #(
  parameter int IW = 10
) (
  input  logic signed [IW-1:0] int_i,
  output logic [7:0]           pix_o
);
  logic neg, ovf;

  assign neg = int_i[IW-1];
  assign ovf = |int_i[IW-2:8];

  always_comb begin
    if (neg)      pix_o = 8'd0;
    else if (ovf) pix_o = 8'd255;
    else          pix_o = int_i[7:0];
  end
endmodule

// File: rtl/qbez_pixel_stepper.sv
module qbez_pixel_stepper
  import qbez_pkg::*;
#(
  parameter int PW    = 28,
  parameter int FRAC  = 18,
  parameter int TBITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_val_i,
  input  logic [PW-1:0] p0_x_i,
  input  logic [PW-1:0] p0_y_i,
  input  logic [PW-1:0] p1_x_i,
  input  logic [PW-1:0] p1_y_i,
  input  logic [PW-1:0] p2_x_i,
  input  logic [PW-1:0] p2_y_i,
  input  logic          out_rdy_i,
  output logic          out_val_o,
  output logic [7:0]    out_x_o,
  output logic [7:0]    out_y_o,
  output logic          done_o
);
  localparam int KW = TBITS + 1;
  localparam int WW = 2 * TBITS + 1;
  localparam int IW = PW - FRAC;
  localparam logic [KW-1:0] K_LAST = KW'(1 << TBITS);
  localparam logic [1:0]    SC_LD  = 2'(PIPE_LAT - 1);

  qbez_st_e st_q;
  logic [KW-1:0] k_q;
  logic [1:0]    sc_q;
  logic          first_q, done_q;
  logic [7:0]    last_q [2];
  logic [7:0]    out_q  [2];
  logic signed [PW-1:0] pt_q [3][2];

  logic [WW-1:0] w0, w1, w2;
  logic [7:0]    pix [2];
  logic          fresh;

  qbez_weight_gen #(.TBITS(TBITS)) u_wgt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .k_i   (k_q),
    .w0_o  (w0),
    .w1_o  (w1),
    .w2_o  (w2)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [IW-1:0] ip;

    qbez_axis_mac #(.PW(PW), .FRAC(FRAC), .TBITS(TBITS)) u_mac (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .p0_i  (pt_q[0][a]),
      .p1_i  (pt_q[1][a]),
      .p2_i  (pt_q[2][a]),
      .w0_i  (w0),
      .w1_i  (w1),
      .w2_i  (w2),
      .int_o (ip)
    );

    qbez_sat #(.IW(IW)) u_sat (
      .int_i(ip),
      .pix_o(pix[a])
    );
  end

  assign fresh = first_q || (pix[0] != last_q[0]) || (pix[1] != last_q[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      sc_q    <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      for (int a = 0; a < 2; a++) begin
        last_q[a] <= '0;
        out_q[a]  <= '0;
        for (int p = 0; p < 3; p++) pt_q[p][a] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (in_val_i) begin
          pt_q[0][0] <= p0_x_i;
          pt_q[0][1] <= p0_y_i;
          pt_q[1][0] <= p1_x_i;
          pt_q[1][1] <= p1_y_i;
          pt_q[2][0] <= p2_x_i;
          pt_q[2][1] <= p2_y_i;
          k_q     <= '0;
          first_q <= 1'b1;
          sc_q    <= SC_LD;
          st_q    <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (sc_q == '0) st_q <= ST_DECIDE;
          else            sc_q <= sc_q - 2'd1;
        end
        ST_DECIDE: begin
          if (fresh) begin
            out_q[0] <= pix[0];
            out_q[1] <= pix[1];
            st_q     <= ST_EMIT;
          end else if (k_q == K_LAST) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            k_q  <= k_q + KW'(1);
            sc_q <= SC_LD;
            st_q <= ST_SETTLE;
          end
        end
        ST_EMIT: if (out_rdy_i) begin
          last_q[0] <= out_q[0];
          last_q[1] <= out_q[1];
          first_q   <= 1'b0;
          if (k_q == K_LAST) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            k_q  <= k_q + KW'(1);
            sc_q <= SC_LD;
            st_q <= ST_SETTLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign out_val_o = (st_q == ST_EMIT);
  assign out_x_o   = out_q[0];
  assign out_y_o   = out_q[1];
  assign done_o    = done_q;
endmodule

// File: rtl/qbez_pixel_stepper_chk.sv
module qbez_pixel_stepper_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       out_rdy_i,
  input logic       out_val_o,
  input logic [7:0] out_x_o,
  input logic [7:0] out_y_o,
  input logic       done_o
);
  logic       have_q;
  logic [7:0] lx_q, ly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      lx_q   <= '0;
      ly_q   <= '0;
    end else if (done_o) begin
      have_q <= 1'b0;
    end else if (out_val_o && out_rdy_i) begin
      have_q <= 1'b1;
      lx_q   <= out_x_o;
      ly_q   <= out_y_o;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_val_o && !out_rdy_i |=> out_val_o && $stable(out_x_o) && $stable(out_y_o)); // R7
  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_val_o && have_q |-> (out_x_o != lx_q) || (out_y_o != ly_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_val_o); // R9
  AST_GAP_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_val_o && out_rdy_i |=> !out_val_o); // R8
endmodule

bind qbez_pixel_stepper qbez_pixel_stepper_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .out_rdy_i(out_rdy_i),
  .out_val_o(out_val_o),
  .out_x_o  (out_x_o),
  .out_y_o  (out_y_o),
  .done_o   (done_o)
);

// File: tb/sim_qbez_pixel_stepper.sv
`timescale 1ns/1ps
module sim_qbez_pixel_stepper;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_val = 1'b0, out_rdy = 1'b0;
  logic [27:0] p0x = '0, p0y = '0, p1x = '0, p1y = '0, p2x = '0, p2y = '0;
  logic out_val, done;
  logic [7:0] ox, oy;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  qbez_pixel_stepper u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_val_i(in_val),
    .p0_x_i(p0x), .p0_y_i(p0y), .p1_x_i(p1x), .p1_y_i(p1y),
    .p2_x_i(p2x), .p2_y_i(p2y), .out_rdy_i(out_rdy),
    .out_val_o(out_val), .out_x_o(ox), .out_y_o(oy), .done_o(done)
  );

  function automatic int pix(longint a, longint b, longint c, int k);
    longint s;
    s = longint'((512 - k) * (512 - k)) * a + longint'(2 * k * (512 - k)) * b + longint'(k * k) * c;
    s = s >>> 36;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return int'(s);
  endfunction

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // behavioural timeline: 3 cycles per parameter step, stall while not ready
  int m_st = 0, m_wait = 0, m_k = 0, m_lx = 0, m_ly = 0, m_ox = 0, m_oy = 0;
  bit m_first = 0, m_done = 0;
  longint m_p [6];
  int acc_x [$], acc_y [$];

  function automatic void m_advance();
    if (m_k == 512) begin
      m_done = 1; m_st = 0;
    end else begin
      m_k++; m_wait = 3; m_st = 1;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_first = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (in_val) begin
          m_p[0] = longint'($signed(p0x)); m_p[1] = longint'($signed(p0y));
          m_p[2] = longint'($signed(p1x)); m_p[3] = longint'($signed(p1y));
          m_p[4] = longint'($signed(p2x)); m_p[5] = longint'($signed(p2y));
          m_k = 0; m_first = 1; m_wait = 3; m_st = 1;
        end
        1: begin
          m_wait--;
          if (m_wait == 0) begin
            int px, py;
            px = pix(m_p[0], m_p[2], m_p[4], m_k);
            py = pix(m_p[1], m_p[3], m_p[5], m_k);
            if (m_first || px != m_lx || py != m_ly) begin
              m_ox = px; m_oy = py; m_st = 2;
            end else m_advance();
          end
        end
        default: if (out_rdy) begin
          m_lx = m_ox; m_ly = m_oy; m_first = 0;
          acc_x.push_back(m_ox); acc_y.push_back(m_oy);
          m_advance();
        end
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(out_val == (m_st == 2), "R8 out_val timing", out_val, m_st == 2);
      chk(done == m_done, "R9 done pulse", done, m_done);
      if (m_st == 2) begin
        chk(ox == m_ox, "R3/R4 pixel x", ox, m_ox);
        chk(oy == m_oy, "R3/R4 pixel y", oy, m_oy);
      end
    end
  end

  task automatic run_curve(input longint ax, ay, bx, by, cx, cy, input int mode);
    int n;
    acc_x.delete(); acc_y.delete();
    @(negedge clk);
    p0x = ax[27:0]; p0y = ay[27:0]; p1x = bx[27:0]; p1y = by[27:0]; p2x = cx[27:0]; p2y = cy[27:0];
    in_val = 1'b1;
    out_rdy = (mode == 0);
    @(negedge clk);
    in_val = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      out_rdy = (mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      // R10: a start strobe with other points mid-segment must be ignored
      in_val = (mode == 2 && (n == 100 || n == 101));
      if (in_val) begin
        p0x = 28'(-100 <<< 18); p1x = 28'(400 <<< 18); p2y = 28'(7 <<< 18);
      end
      @(negedge clk);
      n++;
    end
    in_val = 1'b0;
    chk(done, "R9 segment completes", done, 1);
    chk(acc_x.size() > 0 && acc_x[0] == pix(ax, bx, cx, 0) && acc_y[0] == pix(ay, by, cy, 0),
        "R2/R5 first pixel at t=0", acc_x.size() > 0 ? acc_x[0] : -1, pix(ax, bx, cx, 0));
    chk(acc_x.size() > 0 && acc_x[$] == pix(ax, bx, cx, 512) && acc_y[$] == pix(ay, by, cy, 512),
        "R2 last pixel at t=1", acc_x.size() > 0 ? acc_x[$] : -1, pix(ax, bx, cx, 512));
    for (int i = 1; i < acc_x.size(); i++)
      if (acc_x[i] == acc_x[i-1] && acc_y[i] == acc_y[i-1])
        chk(0, "R6 repeated pixel", acc_x[i], -1);
  endtask

  localparam longint ONE = 64'd262144;

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_val && !done, "R1 outputs in reset", {out_val, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_val && !done, "R1 idle after reset", {out_val, done}, 0);
    // plain curve, consumer always ready
    run_curve(10*ONE, 20*ONE, 200*ONE, 40*ONE, 60*ONE, 230*ONE, 0);
    chk(acc_x.size() > 20, "R2 many distinct pixels", acc_x.size(), 21);
    // R4: curve leaving the range on both sides, random stalls (R7)
    run_curve(-20*ONE, 300*ONE, 128*ONE, 128*ONE, 300*ONE, -50*ONE, 1);
    chk(acc_x[0] == 0 && acc_y[0] == 255, "R4 clamp at start", acc_x[0], 0);
    chk(acc_x[$] == 255 && acc_y[$] == 0, "R4 clamp at end", acc_x[$], 255);
    // R5/R6: all points on one pixel, same pixel as previous end would not matter
    run_curve(77*ONE + ONE/2, 33*ONE, 77*ONE + 3, 33*ONE + 100, 77*ONE, 33*ONE + ONE/4, 0);
    chk(acc_x.size() == 1, "R6 single point for degenerate segment", acc_x.size(), 1);
    run_curve(77*ONE, 33*ONE, 77*ONE, 33*ONE, 77*ONE, 33*ONE, 1);
    chk(acc_x.size() == 1 && acc_x[0] == 77, "R5 first point always offered", acc_x.size(), 1);
    // fractional points, stalls and an ignored start strobe (R10)
    run_curve(5*ONE + ONE/4, 250*ONE + 3*ONE/4, -3*ONE, -3*ONE, 250*ONE + ONE/2, 12*ONE + ONE/8, 2);
    // back-to-back start in the done cycle is accepted (R10)
    in_val = 1'b1;
    p0x = 28'(1 <<< 18); p0y = 28'(2 <<< 18); p1x = 28'(3 <<< 18); p1y = 28'(4 <<< 18);
    p2x = 28'(5 <<< 18); p2y = 28'(6 <<< 18);
    @(negedge clk);
    in_val = 1'b0;
    out_rdy = 1'b1;
    while (!done && cyc < 150000) @(negedge clk);
    chk(done, "R10 start accepted when idle", done, 1);
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule